// File: doc/BRIEF.md
# Burst Receive Nibble Formatter

This block sits behind a burst-mode clock recovery stage. It takes the recovered data one bit per rising edge of the bit-rate clock and presents it on a four-lane output bus. In nibble mode, four consecutive bits form a word. In serial mode, each bit passes straight to lane 0. Next to the data it produces an output clock. That clock runs at full rate or half rate (both-edge capture) depending on the mode. In nibble mode its edge can be placed at one of four positions inside the four-bit data eye.

Clock placement uses half-bit resolution. The shaper updates on both edges of the bit clock. Each half of a bit period is one "slot", and the output clock level is defined per slot. A squelch input forces the clock and the data to zero at once. Two disable inputs act separately: one freezes the data bus and the other parks the clock low. A restart input realigns the nibble boundary to the start of an incoming burst.

Top module: `burst_nib_fmt`

## Requirements
- R1: In nibble mode (`ser_mode`=0, `swap`=0), bits are grouped in fours counted from reset or restart. The earliest bit of a group appears on `dat[3]` and the latest on `dat[0]`. The bus updates only on the rising edge that captures the fourth bit, and holds for four bit periods.
- R2: With `swap`=1 in nibble mode, the lane order is reversed: the earliest bit appears on `dat[0]` and the latest on `dat[3]`.
- R3: In nibble mode with `par_ddr`=0 and `phase`=00, `clk_out` has a period of four bits with a 50% duty cycle. It rises two bit periods after each data change, which is the centre of the eye.
- R4: With `par_ddr`=1 in nibble mode, `clk_out` has a period of eight bits and makes exactly one edge per nibble. Successive edges alternate between rising and falling. The edges sit at the same offset that `phase` selects for the full-rate clock.
- R5: The `phase` code moves the rising edge of the nibble-mode clock relative to the data change. Code 01 adds two bit periods, so the edge lands on the data change. Code 10 adds half a bit period, so the edge comes 2.5 bit periods after the change. Code 11 subtracts 1.5 bit periods, so the edge comes 0.5 bit period after the change.
- R6: With `ser_mode`=1, each bit appears on `dat[0]` one rising edge after it is captured, and `dat[3:1]` are zero. The `phase` field has no effect on the clock in serial mode.
- R7: In serial mode with `ser_full`=0, `clk_out` toggles at the middle of every bit, giving a period of two bits. With `ser_full`=1, `clk_out` is low in the first half of each bit and high in the second half.
- R8: While `squelch` is 1, `dat` and `clk_out` are both zero. Bit counting and clock phase keep running, so after release the outputs match an uninterrupted stream.
- R9: While `dis_data` is 1 at a rising edge, `dat` keeps its previous value. While `dis_clk` is 1, `clk_out` is held low. Neither input disturbs alignment.
- R10: A bit captured with `restart`=1 becomes the earliest bit of a new nibble. Restart also resets the half-rate divider, so the half-rate clock phase counts from that bit.
- R11: While `rst_n` is 0, `dat` and `clk_out` are zero. The first bit captured after release is the earliest bit of a nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; one bit captured per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sin | input | 1 | Recovered serial bit |
| restart | input | 1 | Marks the current bit as the start of a nibble |
| ser_mode | input | 1 | 1 = serial output on lane 0, 0 = nibble output |
| ser_full | input | 1 | Serial mode clock: 1 = full rate, 0 = half rate |
| par_ddr | input | 1 | Nibble mode clock: 1 = half rate, 0 = full rate |
| swap | input | 1 | 1 = earliest bit on lane 0 |
| phase | input | 2 | Nibble-mode clock edge placement code |
| squelch | input | 1 | Forces data and clock outputs to zero |
| dis_data | input | 1 | Freezes the data output |
| dis_clk | input | 1 | Parks the output clock low |
| dat | output | LANES | Output data lanes |
| clk_out | output | 1 | Output clock |

## Verification
A bit counter that is off by one shows up within one nibble. The bus changes on the wrong edge, and every lane carries a bit from a neighbouring group. The same fault moves each clock edge by two slots, which the per-slot check catches in the first bit period. A stale divider parity inverts the half-rate clock over a whole nibble. A wrong entry in the phase table shifts the first rising edge by at least one half-bit slot. Because every slot is sampled, each of these faults appears at the ports within four to eight bit periods of the stimulus.

// File: rtl/bnf_pkg.sv
package bnf_pkg;

   typedef enum logic [1:0] {
      PH_MID   = 2'b00,
      PH_EDGE  = 2'b01,
      PH_LATE  = 2'b10,
      PH_EARLY = 2'b11
   } ck_phase_e;

   // Offset of the rising edge, in half-bit slots, from the eye centre
   function automatic int phase_skew(ck_phase_e ph);
      case (ph)
         PH_EDGE:  return 4;
         PH_LATE:  return 1;
         PH_EARLY: return -3;
         default:  return 0;
      endcase
   endfunction

   // Clock level in a slot: high for the first half of a period of 2**lg
   // slots that starts at slot 'rise'
   function automatic logic level_at(logic [7:0] pos, logic [7:0] rise, int lg);
      logic [7:0] d;
      d = pos - rise;
      return ~d[lg-1];
   endfunction

endpackage

// File: rtl/bnf_gather.sv
module bnf_gather #(
   parameter int LANES = 4,
   localparam int CW = $clog2(LANES),
   localparam int PW = CW + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sin,
   input  logic             restart,
   input  logic             ser_mode,
   output logic [LANES-1:0] word_o,
   output logic             load_o,
   output logic [PW-1:0]    pos_n
);

   logic [CW-1:0]    cnt_q, idx, cnt_n;
   logic [LANES-2:0] sh_q;
   logic             par_q, par_n, spar_q, spar_n;

   assign idx    = restart ? '0 : cnt_q;
   assign load_o = (idx == CW'(LANES - 1));
   assign cnt_n  = load_o ? '0 : idx + 1'b1;
   assign par_n  = restart ? 1'b0 : (par_q ^ load_o);
   assign spar_n = restart ? 1'b1 : ~spar_q;
   assign word_o = {sh_q, sin};

   // slot position of the high half of the coming bit
   assign pos_n = ser_mode ? PW'({spar_n, 1'b0}) : {par_n, cnt_n, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sh_q   <= '0;
         par_q  <= 1'b0;
         spar_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_n;
         sh_q   <= {sh_q[LANES-3:0], sin};
         par_q  <= par_n;
         spar_q <= spar_n;
      end
   end

endmodule

// File: rtl/bnf_ck_shaper.sv
module bnf_ck_shaper
   import bnf_pkg::*;
#(
   parameter int LANES = 4,
   localparam int CW = $clog2(LANES),
   localparam int PW = CW + 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] pos_n,
   input  logic          ser_mode,
   input  logic          ser_full,
   input  logic          par_ddr,
   input  logic [1:0]    phase,
   output logic          ck_o
);

   logic [7:0]    rise;
   int            lg;
   logic [PW-1:0] pos_q;
   logic          hi_q, lo_q;

   always_comb begin
      if (ser_mode) begin
         rise = 8'd1;
         lg   = ser_full ? 1 : 2;
      end else begin
         rise = 8'(LANES + phase_skew(ck_phase_e'(phase)));
         lg   = par_ddr ? CW + 2 : CW + 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         hi_q  <= 1'b0;
      end else begin
         pos_q <= pos_n;
         hi_q  <= level_at(8'(pos_n), rise, lg);
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) lo_q <= 1'b0;
      else        lo_q <= level_at(8'(pos_q) + 8'd1, rise, lg);
   end

   assign ck_o = clk ? hi_q : lo_q;

endmodule

// File: rtl/bnf_out_stage.sv
module bnf_out_stage #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] word_i,
   input  logic             load_i,
   input  logic             sin,
   input  logic             ser_mode,
   input  logic             swap,
   input  logic             squelch,
   input  logic             dis_data,
   input  logic             dis_clk,
   input  logic             ck_i,
   output logic [LANES-1:0] dat_o,
   output logic             ck_o
);

   logic [LANES-1:0] rev, dq;

   for (genvar i = 0; i < LANES; i++) begin : g_rev
      assign rev[i] = word_i[LANES-1-i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dq <= '0;
      else if (!dis_data) begin
         if (ser_mode)    dq <= {{(LANES-1){1'b0}}, sin};
         else if (load_i) dq <= swap ? rev : word_i;
      end
   end

   assign dat_o = squelch ? '0 : dq;
   assign ck_o  = (squelch | dis_clk) ? 1'b0 : ck_i;

endmodule

// File: rtl/burst_nib_fmt.sv
module burst_nib_fmt #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sin,
   input  logic             restart,
   input  logic             ser_mode,
   input  logic             ser_full,
   input  logic             par_ddr,
   input  logic             swap,
   input  logic [1:0]       phase,
   input  logic             squelch,
   input  logic             dis_data,
   input  logic             dis_clk,
   output logic [LANES-1:0] dat,
   output logic             clk_out
);

   localparam int CW = $clog2(LANES);
   localparam int PW = CW + 2;

   if (LANES < 4 || LANES > 64 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two from 4 to 64");
   end

   logic [LANES-1:0] word;
   logic             load;
   logic [PW-1:0]    pos_n;
   logic             ck_raw;

   bnf_gather #(.LANES(LANES)) u_gath (
      .clk(clk), .rst_n(rst_n), .sin(sin), .restart(restart),
      .ser_mode(ser_mode), .word_o(word), .load_o(load), .pos_n(pos_n)
   );

   bnf_ck_shaper #(.LANES(LANES)) u_ck (
      .clk(clk), .rst_n(rst_n), .pos_n(pos_n), .ser_mode(ser_mode),
      .ser_full(ser_full), .par_ddr(par_ddr), .phase(phase), .ck_o(ck_raw)
   );

   bnf_out_stage #(.LANES(LANES)) u_out (
      .clk(clk), .rst_n(rst_n), .word_i(word), .load_i(load), .sin(sin),
      .ser_mode(ser_mode), .swap(swap), .squelch(squelch),
      .dis_data(dis_data), .dis_clk(dis_clk), .ck_i(ck_raw),
      .dat_o(dat), .ck_o(clk_out)
   );

endmodule

// File: rtl/burst_nib_fmt_chk.sv
module burst_nib_fmt_chk #(
   parameter int LANES = 4,
   localparam int CW = $clog2(LANES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sin,
   input logic             restart,
   input logic             ser_mode,
   input logic             squelch,
   input logic             dis_data,
   input logic [LANES-1:0] dat,
   input logic             clk_out,
   input logic             last,
   input logic [CW-1:0]    cnt
);

   p_nibble_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_mode && !$past(ser_mode) && !squelch && !$past(squelch)
       && dat != $past(dat)) |-> $past(last));

   p_serial_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_mode && $past(ser_mode) && !$past(dis_data))
      |-> dat[LANES-1:1] == '0);

   p_serial_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_mode && $past(ser_mode) && !squelch && !$past(dis_data))
      |-> dat[0] == $past(sin));

   p_squelch_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      squelch |-> (dat == '0 && !clk_out));

   p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dis_data) && !squelch && !$past(squelch)) |-> $stable(dat));

   p_restart_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt == CW'(1));

endmodule

bind burst_nib_fmt burst_nib_fmt_chk #(.LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .sin(sin), .restart(restart),
   .ser_mode(ser_mode), .squelch(squelch), .dis_data(dis_data),
   .dat(dat), .clk_out(clk_out), .last(u_gath.load_o), .cnt(u_gath.cnt_q)
);

// File: tb/burst_nib_fmt_bench.sv
`timescale 1ns/1ps
module burst_nib_fmt_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sin = 1'b0, restart = 1'b0;
   logic       ser_mode = 1'b0, ser_full = 1'b0, par_ddr = 1'b0, swap = 1'b0;
   logic [1:0] phase = 2'b00;
   logic       squelch = 1'b0, dis_data = 1'b0, dis_clk = 1'b0;
   logic [3:0] dat;
   logic       clk_out;

   int         n_run = 0, n_fail = 0;
   int         nb = -1;          // index of the last captured bit since restart
   logic [3:0] hist = '0;        // hist[3] earliest of the last four bits
   logic [3:0] exp_dat = '0;
   logic [7:0] lf = 8'hA5;

   always #2 clk = ~clk;

   burst_nib_fmt u_burst_nib_fmt (
      .clk(clk), .rst_n(rst_n), .sin(sin), .restart(restart),
      .ser_mode(ser_mode), .ser_full(ser_full), .par_ddr(par_ddr),
      .swap(swap), .phase(phase), .squelch(squelch), .dis_data(dis_data),
      .dis_clk(dis_clk), .dat(dat), .clk_out(clk_out)
   );

   task automatic chk(input string rq, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic int rise_slot(logic [1:0] ph);
      case (ph)
         2'b01:   return 0;   // on the data change (+2 bits)
         2'b10:   return 5;   // 2.5 bits after change
         2'b11:   return 1;   // 0.5 bit after change
         default: return 4;   // eye centre
      endcase
   endfunction

   function automatic logic exp_ck(int h);
      int p, q, r;
      if (squelch || dis_clk) return 1'b0;
      if (ser_mode) begin
         if (ser_full) return (h == 1);
         p = ((nb + 1) % 2) * 2 + h;
         return ((p + 3) % 4) < 2;
      end
      p = 2 * ((nb + 1) % 4) + h;
      r = rise_slot(phase);
      if (!par_ddr) return ((p - r + 8) % 8) < 4;
      q = (((nb + 1) / 4) % 2) * 8 + p;
      return ((q - r + 16) % 16) < 8;
   endfunction

   function automatic logic [3:0] rev4(logic [3:0] v);
      logic [3:0] o;
      for (int i = 0; i < 4; i++) o[i] = v[3-i];
      return o;
   endfunction

   function automatic logic next_bit();
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      return lf[0];
   endfunction

   // one bit period; entered and left one time unit after a falling edge
   task automatic cyc(input logic b, input logic rs, input string rq_d, input string rq_c);
      sin = b;
      restart = rs;
      @(posedge clk);
      nb = rs ? 0 : nb + 1;
      hist = {hist[2:0], b};
      if (!dis_data) begin
         if (ser_mode)          exp_dat = {3'b000, b};
         else if (nb % 4 == 3)  exp_dat = swap ? rev4(hist) : hist;
      end
      #1;
      chk(rq_d, dat, squelch ? 0 : exp_dat);
      chk(rq_c, clk_out, exp_ck(0));
      @(negedge clk);
      #1;
      chk(rq_d, dat, squelch ? 0 : exp_dat);
      chk(rq_c, clk_out, exp_ck(1));
      restart = 1'b0;
   endtask

   task automatic run(input int nbits, input logic rs0, input string rq_d, input string rq_c);
      for (int i = 0; i < nbits; i++) cyc(next_bit(), rs0 && i == 0, rq_d, rq_c);
   endtask

   task automatic t_reset();
      repeat (2) @(negedge clk);
      #1;
      chk("R11", dat, 0);
      chk("R11", clk_out, 0);
      @(posedge clk);
      #1;
      chk("R11", dat, 0);
      chk("R11", clk_out, 0);
      @(negedge clk);
      #1;
      rst_n = 1'b1;
      run(12, 1'b0, "R11", "R11");
   endtask

   task automatic t_par(input logic sw, input logic ddr, input logic [1:0] ph);
      string rc;
      swap = sw;
      par_ddr = ddr;
      phase = ph;
      ser_mode = 1'b0;
      rc = ddr ? "R4" : (ph == 2'b00 ? "R3" : "R5");
      run(24, 1'b1, sw ? "R2" : "R1", rc);
   endtask

   task automatic t_ser(input logic full);
      ser_mode = 1'b1;
      ser_full = full;
      phase = 2'b11;   // must not matter
      run(12, 1'b1, "R6", "R7");
      phase = 2'b01;
      run(6, 1'b0, "R6", "R6");
      ser_mode = 1'b0;
   endtask

   task automatic t_restart();
      ser_mode = 1'b0;
      swap = 1'b0;
      par_ddr = 1'b1;
      phase = 2'b00;
      run(6, 1'b1, "R10", "R10");
      run(14, 1'b1, "R10", "R10");   // restart two bits into a nibble
      par_ddr = 1'b0;
   endtask

   task automatic t_squelch();
      run(6, 1'b1, "R8", "R8");
      squelch = 1'b1;
      run(9, 1'b0, "R8", "R8");
      squelch = 1'b0;
      run(10, 1'b0, "R8", "R8");
   endtask

   task automatic t_disable();
      ser_mode = 1'b0;
      run(8, 1'b1, "R9", "R9");
      dis_data = 1'b1;
      run(10, 1'b0, "R9", "R9");
      dis_data = 1'b0;
      run(8, 1'b0, "R9", "R9");
      dis_clk = 1'b1;
      run(7, 1'b0, "R9", "R9");
      dis_clk = 1'b0;
      run(6, 1'b0, "R9", "R9");
      ser_mode = 1'b1;
      dis_data = 1'b1;
      run(5, 1'b0, "R9", "R9");
      dis_data = 1'b0;
      ser_mode = 1'b0;
   endtask

   initial begin
      t_reset();
      t_par(1'b0, 1'b0, 2'b00);
      t_par(1'b1, 1'b0, 2'b00);
      t_par(1'b0, 1'b0, 2'b01);
      t_par(1'b0, 1'b0, 2'b10);
      t_par(1'b0, 1'b0, 2'b11);
      t_par(1'b0, 1'b1, 2'b00);
      t_par(1'b0, 1'b1, 2'b10);
      t_par(1'b1, 1'b1, 2'b11);
      t_ser(1'b0);
      t_ser(1'b1);
      t_restart();
      t_squelch();
      t_disable();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule